// File: doc/BRIEF.md
# Dual-Rate Automatic Gain Control Loop

This block is the loop filter of a digital automatic gain control. Each valid magnitude sample is compared with a programmable target level. When the signal is too strong, the forward gain is pulled down by an attack gain. When it is too weak, the gain is pushed up by a decay gain. The result is kept in a fixed-point accumulator, and its integer part drives the gain multiplier further down the datapath. Neither the magnitude computation nor that multiplier is part of this block.

Each loop gain is an 8-bit code. The upper nibble is an exponent and the lower nibble is a mantissa, so the base step is the mantissa divided by two to the power of the exponent. Two complete gain sets are packed into one 32-bit configuration word. A 2-bit select field picks one set directly, or lets a per-sample input pick it. In median mode the gain moves by a fixed step in the direction of the error. In mean mode the step is scaled by the size of the error. The accumulated gain is always kept between a programmable floor and ceiling.

Software reads the gain through a snapshot. A write strobe copies the live gain into a holding register, which is flagged as ready four clocks later. The holding register then stays frozen until the next strobe. When the magnitude comes from a CORDIC stage, the target level should be programmed as 1.64676 times the wanted output magnitude, to cancel the processing gain of that stage.

Top module: `agc_loop`

## Requirements
- R1: While reset is high and on the first cycle after it, `gain_out`, `snap_gain` and `snap_ready` are all zero.
- R2: The gain word is laid out as follows: set-0 decay in bits 31:24, set-1 decay in 23:16, set-0 attack in 15:8 and set-1 attack in 7:0. Inside each 8-bit code, bits 7:4 are the exponent E and bits 3:0 are the mantissa M.
- R3: A valid sample above `cfg_thresh` uses the attack code and lowers the gain. A valid sample below it uses the decay code and raises the gain. A sample equal to the threshold leaves the gain unchanged.
- R4: Median mode (`cfg_median`=1) moves the accumulator by M·2^-E gain LSBs per sample. The accumulator holds 16 fractional bits below the integer gain.
- R5: Mean mode (`cfg_median`=0) moves the accumulator by |mag−thresh|·M·2^-(E+8) gain LSBs per sample.
- R6: `cfg_sel` picks the gain set. 2'b10 selects set 0. 2'b00 selects set 1. 2'b11 selects set 1 whatever `mag_set` is. 2'b01 lets `mag_set` choose (0 for set 0, 1 for set 1).
- R7: After every update the accumulator is clamped so that `cfg_lower` ≤ `gain_out` ≤ `cfg_upper` (the upper bound has a zero fraction). This applies as long as `cfg_lower` ≤ `cfg_upper`.
- R8: When `mag_valid` is low, `gain_out` does not change, whatever `mag_in` does.
- R9: A `snap_wr` pulse copies the `gain_out` value present in that cycle into `snap_gain`. `snap_ready` is low from the clock after the pulse until four clocks after it, and goes high at that point.
- R10: `snap_gain` holds its value between strobes while the live gain keeps moving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_gains | input | 32 | Packed attack/decay codes for both gain sets |
| cfg_upper | input | GAIN_W | Gain ceiling, integer |
| cfg_lower | input | GAIN_W | Gain floor, integer |
| cfg_thresh | input | MAG_W | Target magnitude |
| cfg_sel | input | 2 | Gain set selection mode |
| cfg_median | input | 1 | 1: median settling, 0: mean settling |
| mag_valid | input | 1 | Magnitude sample valid |
| mag_in | input | MAG_W | Magnitude sample |
| mag_set | input | 1 | Per-sample gain set choice |
| snap_wr | input | 1 | Snapshot strobe |
| gain_out | output | GAIN_W | Live forward gain, integer part |
| snap_gain | output | GAIN_W | Held gain snapshot |
| snap_ready | output | 1 | Snapshot is valid |

## Verification
The bench drives a sample exactly at the threshold. A design that treats equality as above or below the threshold would drift the gain there. The select modes are exercised with `mag_set` toggling, so a swapped set, a swapped nibble or an ignored override under 2'b11 gives a wrong step. Steps are run at both limits. These include a ceiling lowered below the current gain, so a missing or inverted clamp shows up as a gain outside the limits. A snapshot is taken while the gain keeps moving, with `snap_ready` sampled on every one of the four clocks after the strobe. This catches an off-by-one latency or a holding register that follows the live value.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef struct packed {
    logic [3:0] ex;
    logic [3:0] man;
  } gcode_t;

  typedef enum logic [1:0] {
    SEL_SET1    = 2'b00,
    SEL_PERSAMP = 2'b01,
    SEL_SET0    = 2'b10,
    SEL_FORCE1  = 2'b11
  } gsel_e;
endpackage

// File: rtl/agc_coef_sel.sv
module agc_coef_sel
  import agc_pkg::*;
(
  input  logic [31:0] gains_word,
  input  logic [1:0]  sel,
  input  logic        samp_set,
  input  logic        attack,
  output gcode_t      code
);
  gcode_t decay_c  [2];
  gcode_t attack_c [2];
  logic   use_set1;

  // set s: decay in the high half, attack in the low half, set 0 first
  generate
    for (genvar s = 0; s < 2; s++) begin : g_set
      assign decay_c[s]  = gcode_t'(gains_word[31-8*s -: 8]);
      assign attack_c[s] = gcode_t'(gains_word[15-8*s -: 8]);
    end
  endgenerate

  always_comb begin
    unique case (gsel_e'(sel))
      SEL_SET0:    use_set1 = 1'b0;
      SEL_PERSAMP: use_set1 = samp_set;
      default:     use_set1 = 1'b1;
    endcase
    code = attack ? attack_c[use_set1] : decay_c[use_set1];
  end
endmodule

// File: rtl/agc_step.sv
module agc_step
  import agc_pkg::*;
#(
  parameter int MAG_W     = 16,
  parameter int FRAC_W    = 16,
  parameter int ERR_SHIFT = 8,
  localparam int PROD_W   = MAG_W + 4,
  localparam int DLT_W    = PROD_W + FRAC_W
) (
  input  gcode_t             code,
  input  logic [MAG_W-1:0]   err_mag,
  input  logic               median,
  output logic [DLT_W-1:0]   delta
);
  logic [PROD_W-1:0] prod;
  logic [DLT_W-1:0]  mean_d;
  logic [DLT_W-1:0]  med_d;

  always_comb begin
    prod   = PROD_W'(err_mag) * PROD_W'(code.man);
    mean_d = {prod, {FRAC_W{1'b0}}} >> (code.ex + ERR_SHIFT);
    med_d  = DLT_W'({code.man, {FRAC_W{1'b0}}}) >> code.ex;
    delta  = median ? med_d : mean_d;
  end
endmodule

// File: rtl/agc_accum.sv
module agc_accum #(
  parameter int GAIN_W = 16,
  parameter int FRAC_W = 16,
  parameter int DLT_W  = 36,
  localparam int ACC_W = GAIN_W + FRAC_W,
  localparam int SUM_W = ((ACC_W > DLT_W) ? ACC_W : DLT_W) + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic              dec,
  input  logic [DLT_W-1:0]  delta,
  input  logic [GAIN_W-1:0] up_lim,
  input  logic [GAIN_W-1:0] lo_lim,
  output logic [GAIN_W-1:0] gain
);
  logic [ACC_W-1:0]        acc;
  logic signed [SUM_W-1:0] cur, dlt, raw, hi, lo, nxt;

  always_comb begin
    cur = $signed({{(SUM_W-ACC_W){1'b0}}, acc});
    dlt = $signed({{(SUM_W-DLT_W){1'b0}}, delta});
    hi  = $signed({{(SUM_W-ACC_W){1'b0}}, up_lim, {FRAC_W{1'b0}}});
    lo  = $signed({{(SUM_W-ACC_W){1'b0}}, lo_lim, {FRAC_W{1'b0}}});
    raw = dec ? (cur - dlt) : (cur + dlt);
    if (raw > hi)      nxt = hi;
    else if (raw < lo) nxt = lo;
    else               nxt = raw;
  end

  always_ff @(posedge clk) begin
    if (rst)      acc <= '0;
    else if (upd) acc <= nxt[ACC_W-1:0];
  end

  assign gain = acc[ACC_W-1 -: GAIN_W];
endmodule

// File: rtl/agc_snapshot.sv
module agc_snapshot #(
  parameter int GAIN_W   = 16,
  parameter int SNAP_LAT = 4,
  localparam int CW      = $clog2(SNAP_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [GAIN_W-1:0] live,
  output logic [GAIN_W-1:0] held,
  output logic              ready
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      held  <= '0;
      ready <= 1'b0;
    end else if (wr) begin
      held  <= live;
      cnt   <= CW'(SNAP_LAT);
      ready <= 1'b0;
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) ready <= 1'b1;
    end
  end
endmodule

// File: rtl/agc_loop.sv
module agc_loop
  import agc_pkg::*;
#(
  parameter int MAG_W     = 16,
  parameter int GAIN_W    = 16,
  parameter int FRAC_W    = 16,
  parameter int ERR_SHIFT = 8,
  parameter int SNAP_LAT  = 4,
  localparam int DLT_W    = MAG_W + 4 + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       cfg_gains,
  input  logic [GAIN_W-1:0] cfg_upper,
  input  logic [GAIN_W-1:0] cfg_lower,
  input  logic [MAG_W-1:0]  cfg_thresh,
  input  logic [1:0]        cfg_sel,
  input  logic              cfg_median,
  input  logic              mag_valid,
  input  logic [MAG_W-1:0]  mag_in,
  input  logic              mag_set,
  input  logic              snap_wr,
  output logic [GAIN_W-1:0] gain_out,
  output logic [GAIN_W-1:0] snap_gain,
  output logic              snap_ready
);
  logic             above, upd;
  logic [MAG_W-1:0] err_mag;
  gcode_t           code;
  logic [DLT_W-1:0] delta;

  always_comb begin
    above   = mag_in > cfg_thresh;
    err_mag = above ? (mag_in - cfg_thresh) : (cfg_thresh - mag_in);
    upd     = mag_valid && (mag_in != cfg_thresh);
  end

  agc_coef_sel u_sel (
    .gains_word (cfg_gains),
    .sel        (cfg_sel),
    .samp_set   (mag_set),
    .attack     (above),
    .code       (code)
  );

  agc_step #(.MAG_W(MAG_W), .FRAC_W(FRAC_W), .ERR_SHIFT(ERR_SHIFT)) u_step (
    .code    (code),
    .err_mag (err_mag),
    .median  (cfg_median),
    .delta   (delta)
  );

  agc_accum #(.GAIN_W(GAIN_W), .FRAC_W(FRAC_W), .DLT_W(DLT_W)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .upd    (upd),
    .dec    (above),
    .delta  (delta),
    .up_lim (cfg_upper),
    .lo_lim (cfg_lower),
    .gain   (gain_out)
  );

  agc_snapshot #(.GAIN_W(GAIN_W), .SNAP_LAT(SNAP_LAT)) u_snap (
    .clk   (clk),
    .rst   (rst),
    .wr    (snap_wr),
    .live  (gain_out),
    .held  (snap_gain),
    .ready (snap_ready)
  );
endmodule

// File: rtl/agc_loop_chk.sv
module agc_loop_chk #(
  parameter int MAG_W    = 16,
  parameter int GAIN_W   = 16,
  parameter int SNAP_LAT = 4,
  localparam int SW      = $clog2(SNAP_LAT + 2) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              mag_valid,
  input logic [MAG_W-1:0]  mag_in,
  input logic [MAG_W-1:0]  cfg_thresh,
  input logic [GAIN_W-1:0] cfg_upper,
  input logic [GAIN_W-1:0] cfg_lower,
  input logic              snap_wr,
  input logic [GAIN_W-1:0] gain_out,
  input logic [GAIN_W-1:0] snap_gain,
  input logic              snap_ready
);
  logic [SW-1:0] since_wr;

  always_ff @(posedge clk) begin
    if (rst)                          since_wr <= '0;
    else if (snap_wr)                 since_wr <= '0;
    else if (since_wr <= SW'(SNAP_LAT)) since_wr <= since_wr + SW'(1);
  end

  assert_reset_zero_R1: assert property (@(posedge clk)
    $past(rst) |-> (gain_out == '0 && snap_gain == '0 && !snap_ready));

  assert_hold_equal_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mag_valid && mag_in == cfg_thresh)) |-> $stable(gain_out));

  assert_attack_down_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mag_valid && mag_in > cfg_thresh && gain_out >= cfg_lower
                          && cfg_lower <= cfg_upper))
    |-> gain_out <= $past(gain_out));

  assert_decay_up_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mag_valid && mag_in < cfg_thresh && gain_out <= cfg_upper
                          && cfg_lower <= cfg_upper))
    |-> gain_out >= $past(gain_out));

  assert_in_limits_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mag_valid && cfg_lower <= cfg_upper))
    |-> (gain_out >= $past(cfg_lower) && gain_out <= $past(cfg_upper)));

  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mag_valid)) |-> $stable(gain_out));

  assert_ready_low_R9: assert property (@(posedge clk) disable iff (rst)
    $past(snap_wr) |-> !snap_ready);

  assert_ready_latency_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(snap_ready) |-> (since_wr == SW'(SNAP_LAT)));

  assert_snap_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(snap_wr)) |-> $stable(snap_gain));
endmodule

bind agc_loop agc_loop_chk #(.MAG_W(MAG_W), .GAIN_W(GAIN_W), .SNAP_LAT(SNAP_LAT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mag_valid  (mag_valid),
  .mag_in     (mag_in),
  .cfg_thresh (cfg_thresh),
  .cfg_upper  (cfg_upper),
  .cfg_lower  (cfg_lower),
  .snap_wr    (snap_wr),
  .gain_out   (gain_out),
  .snap_gain  (snap_gain),
  .snap_ready (snap_ready)
);

// File: tb/agc_loop_test.sv
`timescale 1ns/1ps
module agc_loop_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_gains  = 32'h03_12_21_14;
  logic [15:0] cfg_upper  = 16'd1000;
  logic [15:0] cfg_lower  = 16'd0;
  logic [15:0] cfg_thresh = 16'd1000;
  logic [1:0]  cfg_sel    = 2'b10;
  logic        cfg_median = 1'b1;
  logic        mag_valid  = 1'b0;
  logic [15:0] mag_in     = '0;
  logic        mag_set    = 1'b0;
  logic        snap_wr    = 1'b0;
  logic [15:0] gain_out, snap_gain;
  logic        snap_ready;

  int     n_chk = 0, n_fail = 0;
  bit     done = 1'b0;
  longint m_acc = 0;

  always #2.5 clk = ~clk;

  agc_loop uut (
    .clk(clk), .rst(rst), .cfg_gains(cfg_gains), .cfg_upper(cfg_upper),
    .cfg_lower(cfg_lower), .cfg_thresh(cfg_thresh), .cfg_sel(cfg_sel),
    .cfg_median(cfg_median), .mag_valid(mag_valid), .mag_in(mag_in),
    .mag_set(mag_set), .snap_wr(snap_wr), .gain_out(gain_out),
    .snap_gain(snap_gain), .snap_ready(snap_ready)
  );

  task automatic check(input longint act, input longint exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // R2/R6: code chosen from the packed word per the select rules
  function automatic bit [7:0] pick(input bit [1:0] sel, input bit ps, input bit atk);
    bit s1;
    s1 = (sel == 2'b10) ? 1'b0 : (sel == 2'b01) ? ps : 1'b1;
    if (atk) return s1 ? cfg_gains[7:0]   : cfg_gains[15:8];
    else     return s1 ? cfg_gains[23:16] : cfg_gains[31:24];
  endfunction

  // R3/R4/R5/R7 reference update in accumulator units (16 fraction bits)
  function automatic longint model(input longint a, input int mag, input bit ps);
    longint d, err, hi, lw;
    bit [7:0] c;
    int th;
    th = int'(cfg_thresh);
    if (mag == th) return a;
    c   = pick(cfg_sel, ps, mag > th);
    err = (mag > th) ? longint'(mag - th) : longint'(th - mag);
    if (cfg_median) d = (longint'(c[3:0]) << 16) >> c[7:4];
    else            d = ((err * longint'(c[3:0])) << 16) >> (c[7:4] + 8);
    a  = (mag > th) ? a - d : a + d;
    hi = longint'(cfg_upper) << 16;
    lw = longint'(cfg_lower) << 16;
    if (a > hi)      a = hi;
    else if (a < lw) a = lw;
    return a;
  endfunction

  task automatic sample(input int mag, input bit ps, input string req);
    @(negedge clk);
    mag_valid = 1'b1; mag_in = 16'(mag); mag_set = ps;
    m_acc = model(m_acc, mag, ps);
    @(negedge clk);
    mag_valid = 1'b0;
    check(longint'(gain_out), m_acc >>> 16, req);
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    check(longint'(gain_out), 0, "R1 gain");
    check(longint'(snap_gain), 0, "R1 snap_gain");
    check(longint'(snap_ready), 0, "R1 snap_ready");
    rst = 1'b0; m_acc = 0;
    @(negedge clk);
    check(longint'(gain_out), 0, "R1 gain after release");
  endtask

  task automatic t_median();
    cfg_sel = 2'b10; cfg_median = 1'b1; cfg_upper = 1000; cfg_lower = 0; cfg_thresh = 1000;
    for (int i = 0; i < 5; i++) sample(500, 1'b0, "R4 median decay set0");
    for (int i = 0; i < 6; i++) sample(2500, 1'b0, "R4 median attack set0");
    sample(1000, 1'b0, "R3 equal threshold holds");
    sample(1000, 1'b1, "R3 equal threshold holds");
  endtask

  task automatic t_select();
    cfg_median = 1'b1;
    cfg_sel = 2'b00; sample(10, 1'b0, "R6 sel00 set1 decay");
    cfg_sel = 2'b11; sample(10, 1'b0, "R6 sel11 overrides mag_set");
    sample(3000, 1'b0, "R6 sel11 attack set1");
    cfg_sel = 2'b01; sample(10, 1'b0, "R2 per-sample set0 decay");
    sample(10, 1'b1, "R2 per-sample set1 decay");
    sample(3000, 1'b1, "R2 per-sample set1 attack");
    sample(3000, 1'b0, "R2 per-sample set0 attack");
    cfg_sel = 2'b10; sample(10, 1'b1, "R6 sel10 ignores mag_set");
  endtask

  task automatic t_mean();
    cfg_median = 1'b0; cfg_sel = 2'b10;
    for (int i = 0; i < 4; i++) sample(900, 1'b0, "R5 mean decay err100");
    sample(200, 1'b0, "R5 mean decay err800");
    sample(1500, 1'b0, "R5 mean attack err500");
    cfg_sel = 2'b00;
    sample(1001, 1'b0, "R5 mean tiny error");
    sample(60000, 1'b0, "R5 mean large error");
  endtask

  task automatic t_clamp();
    cfg_median = 1'b1; cfg_sel = 2'b10; cfg_upper = 20; cfg_lower = 0;
    for (int i = 0; i < 10; i++) sample(0, 1'b0, "R7 ceiling");
    check(longint'(gain_out), 20, "R7 held at ceiling");
    cfg_upper = 12; sample(0, 1'b0, "R7 lowered ceiling");
    cfg_upper = 20; cfg_lower = 9; cfg_sel = 2'b00;
    for (int i = 0; i < 4; i++) sample(3000, 1'b0, "R7 floor");
    check(longint'(gain_out), 9, "R7 held at floor");
    cfg_lower = 0; cfg_upper = 1000;
  endtask

  task automatic t_idle();
    longint g;
    g = longint'(gain_out);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); mag_in = 16'(i * 7000); mag_set = i[0];
    end
    @(negedge clk);
    check(longint'(gain_out), g, "R8 no update without valid");
  endtask

  task automatic t_snapshot();
    longint g;
    cfg_median = 1'b1; cfg_sel = 2'b10;
    sample(100, 1'b0, "R9 setup");
    @(negedge clk); snap_wr = 1'b1; g = longint'(gain_out);
    @(negedge clk); snap_wr = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check(longint'(snap_ready), 0, "R9 ready low before latency");
      @(negedge clk);
    end
    check(longint'(snap_ready), 1, "R9 ready after four clocks");
    check(longint'(snap_gain), g, "R9 captured value");
    for (int i = 0; i < 3; i++) sample(100, 1'b0, "R10 live gain moves");
    check(longint'(snap_gain), g, "R10 snapshot frozen");
    check(longint'(snap_ready), 1, "R10 ready stays");
    @(negedge clk); snap_wr = 1'b1; g = longint'(gain_out);
    @(negedge clk); snap_wr = 1'b0;
    check(longint'(snap_ready), 0, "R9 second strobe drops ready");
    repeat (4) @(negedge clk);
    check(longint'(snap_gain), g, "R9 second capture");
    check(longint'(snap_ready), 1, "R9 second ready");
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    t_reset();
    t_median();
    t_select();
    t_mean();
    t_clamp();
    t_idle();
    t_snapshot();
    t_reset();
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
    end
  end
endmodule